// File: doc/BRIEF.md
# Subranging Multi-Bit Successive-Approximation Sequencer

This block runs the digital side of a 16-bit subranging successive-approximation conversion. A conventional converter makes one comparator decision per step. This one reads a 6-bit flash sub-converter code once per step and settles a whole group of bits from it. The conversion takes three steps, whatever the amplitude: 5 bits, then 5 more, then the final 6. In each step the block presents a partial DAC code to the analog front end. The front end turns the difference between the held input and that code into the flash code. The block then adds the decided group into its running value.

The first two flash readings carry one headroom bit above the five data bits. A set headroom bit means the residue reached the top of the group, and the block adds one more unit of that group's weight. Sums are clamped at full scale. After the third step the final code is published and a one-clock completion pulse is raised. A new conversion is requested with a single-clock start pulse while the block is idle.

Top module: `subsar_conv`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, done, result and dac_code are all zero.
- R2: A start pulse sampled while idle launches a conversion. done is high in the clock cycle that follows the third conversion cycle, so done rises exactly three rising edges after the edge that sampled start, for every amplitude.
- R3: dac_code is zero in the first conversion cycle. In each later conversion cycle it equals the sum accumulated from the earlier cycles, with every undecided lower bit zero unless that sum has saturated.
- R4: In conversion cycles 1 and 2, flash_code[4:0] is the group value and flash_code[5] is the headroom flag. The increment is (flash_code[4:0] + flash_code[5]) times 2^11 in cycle 1 and times 2^6 in cycle 2, so an ideal flash reading gives back the input amplitude.
- R5: In conversion cycle 3 all six bits of flash_code, taken as an unsigned number, are added with weight 2^0.
- R6: Whenever an accumulated sum would exceed 65535, it is clamped to 65535. A clamped value is kept for the rest of the conversion.
- R7: done is high for exactly one clock. result changes only on the edge that raises done and otherwise holds its value, including throughout the next conversion.
- R8: A start pulse during a conversion is ignored: neither the timing of done nor the final value changes.
- R9: dac_code is zero whenever no conversion is in progress, including the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Single-clock request to begin a conversion |
| flash_code | input | 6 | Flash sub-converter reading for the current conversion cycle |
| dac_code | output | 16 | Partial code driven to the DAC during a conversion |
| result | output | 16 | Final conversion code |
| done | output | 1 | One-clock pulse marking a finished conversion |

## Verification
A bound checker keeps its own count of the conversion cycle. On every clock it checks that done follows the third cycle and lasts one clock, and that start pulses during a conversion are not counted. It also checks that result does not move outside a done cycle, that dac_code is zero when idle and in the first cycle and never decreases within a conversion, and that the final value is at least the last partial code. The arithmetic itself can only be shown by the bench's scenarios. These cover the exact weights of the group values, the headroom correction, clamping at full scale, and exact reconstruction of boundary amplitudes. In them a behavioural flash model reacts to the DAC code, and a scoreboard compares every published result.

// File: rtl/subsar_pkg.sv
// Package: shared definitions for the subranging conversion sequencer.
// Assumes every group except the last is one bit narrower than the flash
// reading, and the last group uses the full flash width.
package subsar_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Left shift that gives the weight of conversion cycle k (0-based).
    function automatic int cycle_shift(input int res_w, input int grp_w,
                                       input int num_cyc, input int k);
        if (k >= num_cyc - 1) begin
            return 0;
        end
        return res_w - (k + 1) * grp_w;
    endfunction

endpackage

// File: rtl/subsar_seq.sv
// Module: conversion step sequencer.
// Waits in idle for a start pulse, then walks a fixed number of conversion
// cycles and raises a one-clock done pulse after the last one. Assumes
// NUM_CYC >= 2. Start pulses that arrive while running are ignored.
module subsar_seq
    import subsar_pkg::*;
#(
    parameter int NUM_CYC = 3,
    parameter int CYC_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             launch,
    output logic             busy,
    output logic [CYC_W-1:0] cyc_idx,
    output logic             last_cyc,
    output logic             done
);

    localparam logic [CYC_W-1:0] LAST_IDX = CYC_W'(NUM_CYC - 1);

    seq_state_e state_q;
    logic [CYC_W-1:0] idx_q;
    logic done_q;

    // Decode the accepted start and the position within the conversion.
    always_comb begin
        busy     = (state_q == SEQ_RUN);
        launch   = start && !busy;
        last_cyc = busy && (idx_q == LAST_IDX);
    end

    // Advance through idle and the conversion cycles; pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (launch) begin
                state_q <= SEQ_RUN;
                idx_q   <= '0;
            end else if (busy) begin
                if (idx_q == LAST_IDX) begin
                    state_q <= SEQ_IDLE;
                    idx_q   <= '0;
                    done_q  <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign cyc_idx = idx_q;
    assign done    = done_q;

endmodule

// File: rtl/subsar_decode.sv
// Module: flash reading decoder.
// Turns a flash reading into an unshifted group increment. In the non-final
// cycles the low GRP_W bits are the group value and the top bit is a
// headroom flag worth one more group unit. In the final cycle the whole
// reading is the value. Assumes GRP_W == FLASH_W - 1.
module subsar_decode #(
    parameter int FLASH_W = 6,
    parameter int GRP_W   = 5
) (
    input  logic [FLASH_W-1:0] flash_code,
    input  logic               last_cyc,
    output logic [FLASH_W-1:0] inc
);

    logic [FLASH_W-1:0] grp_val;
    logic [FLASH_W-1:0] headroom;

    // Split the reading into group value and headroom correction.
    always_comb begin
        grp_val  = FLASH_W'(flash_code[GRP_W-1:0]);
        headroom = FLASH_W'(flash_code[FLASH_W-1]);
    end

    // Pick the final-cycle or corrected-group interpretation.
    always_comb begin
        if (last_cyc) begin
            inc = flash_code;
        end else begin
            inc = grp_val + headroom;
        end
    end

endmodule

// File: rtl/subsar_accum.sv
// Module: weighted saturating accumulator.
// Weights each cycle's increment by that cycle's group position, adds it
// to the running value with a clamp at full scale, and latches the final
// code on the last cycle. Assumes the increment shifted by any cycle weight
// fits in RES_W+1 bits.
module subsar_accum
    import subsar_pkg::*;
#(
    parameter int RES_W   = 16,
    parameter int FLASH_W = 6,
    parameter int GRP_W   = 5,
    parameter int NUM_CYC = 3,
    parameter int CYC_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic               busy,
    input  logic               last_cyc,
    input  logic [CYC_W-1:0]   cyc_idx,
    input  logic [FLASH_W-1:0] inc,
    output logic [RES_W-1:0]   acc,
    output logic [RES_W-1:0]   result
);

    localparam int SUM_W = RES_W + 1;

    logic [SUM_W-1:0] weighted [NUM_CYC];
    logic [SUM_W-1:0] sel_w;
    logic [SUM_W-1:0] sum;
    logic [RES_W-1:0] sum_sat;
    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] res_q;

    // One weighted copy of the increment per conversion cycle.
    for (genvar g = 0; g < NUM_CYC; g++) begin : g_weight
        localparam int SH = cycle_shift(RES_W, GRP_W, NUM_CYC, g);
        assign weighted[g] = SUM_W'(inc) << SH;
    end

    // Select the weighted increment that belongs to the current cycle.
    always_comb begin
        sel_w = '0;
        for (int k = 0; k < NUM_CYC; k++) begin
            if (cyc_idx == CYC_W'(k)) begin
                sel_w = weighted[k];
            end
        end
    end

    // Add and clamp at full scale.
    always_comb begin
        sum     = SUM_W'(acc_q) + sel_w;
        sum_sat = sum[RES_W] ? {RES_W{1'b1}} : sum[RES_W-1:0];
    end

    // Running value: cleared on launch, updated every conversion cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (launch) begin
            acc_q <= '0;
        end else if (busy) begin
            acc_q <= sum_sat;
        end
    end

    // Published code: loaded only when the final cycle completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (last_cyc) begin
            res_q <= sum_sat;
        end
    end

    assign acc    = acc_q;
    assign result = res_q;

endmodule

// File: rtl/subsar_conv.sv
// Module: subranging multi-bit successive-approximation sequencer (top).
// Resolves RES_W bits in a fixed number of cycles from a FLASH_W-bit flash
// reading per cycle. Assumes (RES_W - FLASH_W) is a multiple of FLASH_W-1
// and that the flash reading is settled for the current dac_code before
// each rising edge.
module subsar_conv #(
    parameter int RES_W   = 16,
    parameter int FLASH_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FLASH_W-1:0] flash_code,
    output logic [RES_W-1:0]   dac_code,
    output logic [RES_W-1:0]   result,
    output logic               done
);

    localparam int GRP_W   = FLASH_W - 1;
    localparam int NUM_CYC = 1 + (RES_W - FLASH_W) / GRP_W;
    localparam int CYC_W   = (NUM_CYC > 1) ? $clog2(NUM_CYC) : 1;

    logic               launch;
    logic               busy;
    logic               last_cyc;
    logic [CYC_W-1:0]   cyc_idx;
    logic [FLASH_W-1:0] inc;
    logic [RES_W-1:0]   acc;

    subsar_seq #(
        .NUM_CYC (NUM_CYC),
        .CYC_W   (CYC_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .launch   (launch),
        .busy     (busy),
        .cyc_idx  (cyc_idx),
        .last_cyc (last_cyc),
        .done     (done)
    );

    subsar_decode #(
        .FLASH_W (FLASH_W),
        .GRP_W   (GRP_W)
    ) u_decode (
        .flash_code (flash_code),
        .last_cyc   (last_cyc),
        .inc        (inc)
    );

    subsar_accum #(
        .RES_W   (RES_W),
        .FLASH_W (FLASH_W),
        .GRP_W   (GRP_W),
        .NUM_CYC (NUM_CYC),
        .CYC_W   (CYC_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .busy     (busy),
        .last_cyc (last_cyc),
        .cyc_idx  (cyc_idx),
        .inc      (inc),
        .acc      (acc),
        .result   (result)
    );

    // Present the partial code only while converting.
    always_comb begin
        dac_code = busy ? acc : '0;
    end

endmodule

// File: rtl/subsar_conv_chk.sv
// Module: protocol checker for subsar_conv, attached with bind.
// Keeps its own count of the conversion cycle from start and done, and
// checks timing and code properties against the ports.
module subsar_conv_chk #(
    parameter int RES_W   = 16,
    parameter int NUM_CYC = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [RES_W-1:0] dac_code,
    input logic [RES_W-1:0] result,
    input logic             done
);

    localparam int CNT_W = $clog2(NUM_CYC + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_CYC);

    logic [CNT_W-1:0] cnt;

    // Independent cycle count: 0 idle, k during conversion cycle k.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == '0) begin
            if (start) begin
                cnt <= CNT_W'(1);
            end
        end else if (cnt == CNT_LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2 R8
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_LAST) |=> done);

    // R2
    done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(cnt) == CNT_LAST));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R9
    dac_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (dac_code == '0));

    // R3
    dac_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_W'(1)) |-> (dac_code == '0));

    // R3 R6
    dac_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > CNT_W'(1)) |-> (dac_code >= $past(dac_code)));

    // R6
    result_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result >= $past(dac_code)));

endmodule

bind subsar_conv subsar_conv_chk #(
    .RES_W   (RES_W),
    .NUM_CYC (NUM_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dac_code (dac_code),
    .result   (result),
    .done     (done)
);

// File: tb/test_subsar_conv.sv
// Bench: scoreboard test for subsar_conv. The driver plays a behavioural
// flash model against dac_code and queues each expected code. The monitor
// compares published results and checks that result holds between them.
module test_subsar_conv;

    localparam int CLK_PERIOD = 10;
    localparam int RES_W      = 16;
    localparam int FLASH_W    = 6;
    localparam int FULL       = 65535;

    logic               clk;
    logic               rst_n;
    logic               start;
    logic [FLASH_W-1:0] flash_code;
    logic [RES_W-1:0]   dac_code;
    logic [RES_W-1:0]   result;
    logic               done;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    int          exp_q [$];
    int          last_res = 0;
    bit          mon_en = 1'b0;
    bit          finished = 1'b0;

    subsar_conv #(
        .RES_W   (RES_W),
        .FLASH_W (FLASH_W)
    ) i_subsar_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .flash_code (flash_code),
        .dac_code   (dac_code),
        .result     (result),
        .done       (done)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver. mode 0: ideal flash; 1: cycle 1 reads one group low;
    // 2: cycle 1 reads all ones. poke: start again in cycle 2 (ignored).
    // b2b: start in the current (done) cycle without an idle gap.
    task automatic convert(input int amp, input int mode, input bit poke,
                           input bit b2b);
        int acc;
        acc = 0;
        if (!b2b) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            int sh;
            int res;
            int u;
            int code;
            int inc;
            start = 1'b0;
            chk("R3 dac_code", int'(dac_code), acc);
            if (k == 0) chk("R7 done low in cycle 1", int'(done), 0);
            sh  = (k == 0) ? 11 : ((k == 1) ? 6 : 0);
            res = amp - int'(dac_code);
            u   = (res < 0) ? 0 : (res >>> sh);
            if (k < 2) code = (u >= 32) ? 63 : u;
            else       code = (u > 63) ? 63 : u;
            if (k == 0 && mode == 1 && u > 0) code = u - 1;
            if (k == 0 && mode == 2) code = 63;
            flash_code = FLASH_W'(code);
            inc = (k < 2) ? ((code % 32) + (code / 32)) : code;
            acc = acc + (inc << sh);
            if (acc > FULL) acc = FULL;
            if (k == 2) exp_q.push_back(acc);
            if (poke && k == 1) start = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R2 done three edges after start", int'(done), 1);
        chk("R9 dac_code zero in done cycle", int'(dac_code), 0);
        if (mode == 0) chk("R4 R5 ideal flash reproduces amplitude", acc, amp);
    endtask

    // Monitor: scoreboard compare on done, hold check otherwise.
    always @(negedge clk) begin
        if (mon_en) begin
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected done", 1, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk("R4 R5 R6 result", int'(result), e);
                end
                last_res = int'(result);
            end else begin
                chk("R7 result held", int'(result), last_res);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        flash_code = '0;
        repeat (3) @(negedge clk);
        // R1: values while in reset
        chk("R1 done in reset", int'(done), 0);
        chk("R1 result in reset", int'(result), 0);
        chk("R1 dac_code in reset", int'(dac_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", int'(done), 0);
        chk("R9 dac_code idle", int'(dac_code), 0);
        mon_en = 1'b1;

        // R4 R5: ideal flash over boundary and mixed amplitudes
        convert(0, 0, 1'b0, 1'b0);
        convert(1, 0, 1'b0, 1'b0);
        convert(16'h003F, 0, 1'b0, 1'b0);
        convert(16'h07FF, 0, 1'b0, 1'b0);
        convert(16'h0800, 0, 1'b0, 1'b0);
        convert(16'h5A5A, 0, 1'b0, 1'b0);
        convert(16'h8421, 0, 1'b0, 1'b0);
        convert(FULL, 0, 1'b0, 1'b0);

        // R4: headroom correction after a low cycle-1 reading
        convert(16'h5A5A, 1, 1'b0, 1'b0);
        convert(16'h3000, 1, 1'b0, 1'b0);

        // R6: clamp to full scale from cycle 1
        convert(FULL, 2, 1'b0, 1'b0);
        convert(16'h1234, 2, 1'b0, 1'b0);

        // R8: start during conversion ignored
        convert(16'h2222, 0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R8 no second conversion", int'(done), 0);
        chk("R9 dac_code idle after stray start", int'(dac_code), 0);

        // R2 R7: back-to-back conversions started in the done cycle
        convert(16'h1357, 0, 1'b0, 1'b0);
        convert(16'hBEEF, 0, 1'b0, 1'b1);
        convert(16'h0042, 0, 1'b0, 1'b1);

        repeat (4) @(negedge clk);
        chk("R7 all results published", exp_q.size(), 0);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule